// File: doc/BRIEF.md
# PHY Interface Control Register with VBUS Indicator Conditioning

This block holds one 8-bit control register for a USB PHY interface. A simple register-access port (address, write data, write strobe, read data) reaches it through three aliased addresses. One address loads a new value. A second address ORs the write data into the register. A third clears each bit where the write data holds a 1. A read from any of the three addresses returns the same contents. A read from any other address returns zero, and a write to any other address has no effect.

The register drives several PHY options:

- the 6-pin and 3-pin serial-mode enables,
- the active-low clock-suspend control, which keeps the clock running in serial modes,
- the autoresume enable,
- two options that shape the external VBUS indicator.

The PHY hardware can clear either serial-mode enable when that serial mode ends. The block also computes, combinationally, the VBUS state reported upstream. The external indicator input is first inverted or passed straight through to form a complement signal. That signal is then either qualified with the internal VBUS-valid comparator or reported directly.

Top module: `phy_ifc_ctrl_reg`

## Requirements
- R1: After reset every register bit is 0, so reads return 8'h00 and all option outputs are 0.
- R2: A write to address 8'h07 replaces the register with the write data. Bits 2 and 7 are forced to 0.
- R3: A write to address 8'h08 ORs the write data into the register.
- R4: A write to address 8'h09 clears every register bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: Addresses 8'h07, 8'h08 and 8'h09 read back the same value. Any other address reads 8'h00, and a write to any other address leaves the register unchanged.
- R6: Bit 2 (reserved) and bit 7 (unused) always read 0. Loads, sets and clears do not change them.
- R7: A pulse on `ser_exit[0]` clears bit 0 (6-pin serial enable), and a pulse on `ser_exit[1]` clears bit 1 (3-pin serial enable). If a software set of the same bit happens in the same cycle, the hardware clear wins.
- R8: The option outputs follow the register bits: bit 0 → `ser6_en`, bit 1 → `ser3_en`, bit 3 → `clk_keep_en` (1 means the clock is output in serial modes), bit 4 → `autoresume_en`.
- R9: `vbus_compl` equals `ext_vbus_ind` when bit 5 is 0, and equals its inverse when bit 5 is 1.
- R10: When bit 6 is 0, `vbus_state` equals `vbus_compl` AND `vbus_cmp_valid`. When bit 6 is 1, `vbus_state` equals `vbus_compl`.
- R11: The register changes only on the clock edge that follows a cycle with the write strobe high (or with an exit pulse high). Read data is combinational from the current register value and the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | 8 | Register-access address |
| acc_wdata | input | 8 | Write data |
| acc_we | input | 1 | Write strobe |
| acc_rdata | output | 8 | Read data (combinational) |
| ser_exit | input | 2 | Serial-mode exit pulses: [0] 6-pin, [1] 3-pin |
| ext_vbus_ind | input | 1 | External VBUS indicator input |
| vbus_cmp_valid | input | 1 | Internal VBUS-valid comparator result |
| ser6_en | output | 1 | 6-pin serial mode enable |
| ser3_en | output | 1 | 3-pin serial mode enable |
| clk_keep_en | output | 1 | Clock output in serial modes (active-low suspend) |
| autoresume_en | output | 1 | Automatic resume signaling enable |
| vbus_compl | output | 1 | Indicator after optional inversion |
| vbus_state | output | 1 | VBUS state reported upstream |

## Verification
Register effects are due one clock edge after the write or exit pulse. The bench drives the strobe on a falling edge and samples one full cycle later, on the next falling edge. It also takes one sample before the intervening rising edge, to confirm that nothing changes early. Read data and the two VBUS outputs are combinational, so the bench checks them 1 ns after it changes the address or the indicator inputs, with no clock edge in between.

// File: rtl/ifc_ctrl_pkg.sv
// Package: shared constants for the PHY interface control register.
// Assumes an 8-bit register and 8-bit addresses by default.
package ifc_ctrl_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 8;

    // Bit positions decoded by neighbouring logic
    localparam int B_SER6   = 0;
    localparam int B_SER3   = 1;
    localparam int B_RSVD   = 2;
    localparam int B_CLKKEEP = 3;
    localparam int B_AUTORES = 4;
    localparam int B_INVERT = 5;
    localparam int B_PASS   = 6;
    localparam int B_UNUSED = 7;

    // Bits that hold state; all others read as zero
    localparam logic [REG_W-1:0] IMPL_MASK = 8'b0111_1011;

    localparam logic [ADDR_W-1:0] A_LOAD = 8'h07;
    localparam logic [ADDR_W-1:0] A_SET  = 8'h08;
    localparam logic [ADDR_W-1:0] A_CLR  = 8'h09;
endpackage

// File: rtl/ifc_addr_decode.sv
// Module: ifc_addr_decode
// Decodes the access address into load/set/clear write enables and a
// read-hit flag. Assumes the three alias addresses are distinct.
module ifc_addr_decode #(
    parameter int ADDR_W = ifc_ctrl_pkg::ADDR_W,
    parameter logic [ADDR_W-1:0] LOAD_ADDR = ifc_ctrl_pkg::A_LOAD,
    parameter logic [ADDR_W-1:0] SET_ADDR  = ifc_ctrl_pkg::A_SET,
    parameter logic [ADDR_W-1:0] CLR_ADDR  = ifc_ctrl_pkg::A_CLR
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic              load_en,
    output logic              set_en,
    output logic              clr_en,
    output logic              rd_hit
);
    logic hit_load, hit_set, hit_clr;

    // Compare address against each alias
    always_comb begin
        hit_load = (addr == LOAD_ADDR);
        hit_set  = (addr == SET_ADDR);
        hit_clr  = (addr == CLR_ADDR);
    end

    // Qualify hits with the write strobe
    always_comb begin
        load_en = we & hit_load;
        set_en  = we & hit_set;
        clr_en  = we & hit_clr;
        rd_hit  = hit_load | hit_set | hit_clr;
    end
endmodule

// File: rtl/ifc_reg_core.sv
// Module: ifc_reg_core
// Per-bit storage with load/set/clear access and a hardware clear that
// takes priority over every software access. Bits outside IMPL_MASK
// have no flop and are tied to zero. Synchronous active-low reset.
module ifc_reg_core #(
    parameter int                REG_W     = ifc_ctrl_pkg::REG_W,
    parameter logic [REG_W-1:0]  IMPL_MASK = ifc_ctrl_pkg::IMPL_MASK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] hw_clr,
    output logic [REG_W-1:0] q
);
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_impl
            logic nxt;

            // Next value: software access first, then hardware clear
            always_comb begin
                nxt = q[i];
                if (load_en) nxt = wdata[i];
                if (set_en && wdata[i]) nxt = 1'b1;
                if (clr_en && wdata[i]) nxt = 1'b0;
                if (hw_clr[i]) nxt = 1'b0;
            end

            // Storage flop with synchronous reset
            always_ff @(posedge clk) begin
                if (!rst_n) q[i] <= 1'b0;
                else        q[i] <= nxt;
            end
        end else begin : g_tie
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/vbus_ind_cond.sv
// Module: vbus_ind_cond
// Combinational conditioning of the external VBUS indicator: optional
// inversion, then optional qualification with the internal comparator.
module vbus_ind_cond (
    input  logic ind_in,
    input  logic cmp_valid,
    input  logic invert,
    input  logic pass_thru,
    output logic compl_out,
    output logic state_out
);
    // Inversion stage
    always_comb compl_out = ind_in ^ invert;

    // Qualification stage
    always_comb state_out = pass_thru ? compl_out : (compl_out & cmp_valid);
endmodule

// File: rtl/phy_ifc_ctrl_reg.sv
// Module: phy_ifc_ctrl_reg (top)
// PHY interface control register reachable at three aliased addresses
// (load, set, clear), with hardware auto-clear of the serial-mode bits
// and conditioning of the external VBUS indicator. Assumes ser_exit
// pulses are synchronous to clk. Read data is combinational.
module phy_ifc_ctrl_reg
    import ifc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [REG_W-1:0]  acc_wdata,
    input  logic              acc_we,
    output logic [REG_W-1:0]  acc_rdata,
    input  logic [1:0]        ser_exit,
    input  logic              ext_vbus_ind,
    input  logic              vbus_cmp_valid,
    output logic              ser6_en,
    output logic              ser3_en,
    output logic              clk_keep_en,
    output logic              autoresume_en,
    output logic              vbus_compl,
    output logic              vbus_state
);
    logic             load_en, set_en, clr_en, rd_hit;
    logic [REG_W-1:0] hw_clr;
    logic [REG_W-1:0] reg_q;

    ifc_addr_decode u_dec (
        .addr    (acc_addr),
        .we      (acc_we),
        .load_en (load_en),
        .set_en  (set_en),
        .clr_en  (clr_en),
        .rd_hit  (rd_hit)
    );

    // Map exit pulses onto the serial-mode bit positions
    always_comb begin
        hw_clr         = '0;
        hw_clr[B_SER6] = ser_exit[0];
        hw_clr[B_SER3] = ser_exit[1];
    end

    ifc_reg_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .set_en  (set_en),
        .clr_en  (clr_en),
        .wdata   (acc_wdata),
        .hw_clr  (hw_clr),
        .q       (reg_q)
    );

    vbus_ind_cond u_vbus (
        .ind_in    (ext_vbus_ind),
        .cmp_valid (vbus_cmp_valid),
        .invert    (reg_q[B_INVERT]),
        .pass_thru (reg_q[B_PASS]),
        .compl_out (vbus_compl),
        .state_out (vbus_state)
    );

    // Read mux and option outputs
    always_comb begin
        acc_rdata     = rd_hit ? reg_q : '0;
        ser6_en       = reg_q[B_SER6];
        ser3_en       = reg_q[B_SER3];
        clk_keep_en   = reg_q[B_CLKKEEP];
        autoresume_en = reg_q[B_AUTORES];
    end
endmodule

// File: rtl/phy_ifc_ctrl_reg_chk.sv
// Module: phy_ifc_ctrl_reg_chk
// Checker bound to phy_ifc_ctrl_reg; observes ports and the register state.
module phy_ifc_ctrl_reg_chk
    import ifc_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [REG_W-1:0]  acc_wdata,
    input logic              acc_we,
    input logic [REG_W-1:0]  acc_rdata,
    input logic [1:0]        ser_exit,
    input logic              ext_vbus_ind,
    input logic              vbus_cmp_valid,
    input logic              ser6_en,
    input logic              clk_keep_en,
    input logic              autoresume_en,
    input logic              vbus_compl,
    input logic              vbus_state,
    input logic [REG_W-1:0]  reg_q
);
    // R6: reserved and unused bits never read as 1
    a_r6_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rdata[B_RSVD] == 1'b0) && (acc_rdata[B_UNUSED] == 1'b0));

    // R7: exit pulse clears the 6-pin enable, even against a set
    a_r7_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ser_exit[0] |=> !ser6_en);

    // R3: set of bit 4 lands on the next edge
    a_r3_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && acc_addr == A_SET && acc_wdata[B_AUTORES]) |=> autoresume_en);

    // R4: clear of bit 3 lands on the next edge
    a_r4_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && acc_addr == A_CLR && acc_wdata[B_CLKKEEP]) |=> !clk_keep_en);

    // R11: no strobe and no exit pulse means no change
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_we && ser_exit == 2'b00) |=> $stable(reg_q));

    // R10: qualified mode blocks the state when the comparator is low
    a_r10_qualify: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_q[B_PASS] && !vbus_cmp_valid) |-> !vbus_state);

    // R9: without inversion the complement follows the input
    a_r9_no_invert: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_q[B_INVERT] |-> (vbus_compl == ext_vbus_ind));
endmodule

bind phy_ifc_ctrl_reg phy_ifc_ctrl_reg_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc_addr       (acc_addr),
    .acc_wdata      (acc_wdata),
    .acc_we         (acc_we),
    .acc_rdata      (acc_rdata),
    .ser_exit       (ser_exit),
    .ext_vbus_ind   (ext_vbus_ind),
    .vbus_cmp_valid (vbus_cmp_valid),
    .ser6_en        (ser6_en),
    .clk_keep_en    (clk_keep_en),
    .autoresume_en  (autoresume_en),
    .vbus_compl     (vbus_compl),
    .vbus_state     (vbus_state),
    .reg_q          (reg_q)
);

// File: tb/phy_ifc_ctrl_reg_bench.sv
// Directed bench for phy_ifc_ctrl_reg: one task per scenario.
module phy_ifc_ctrl_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc_addr = 8'h00;
    logic [7:0] acc_wdata = 8'h00;
    logic       acc_we = 1'b0;
    logic [7:0] acc_rdata;
    logic [1:0] ser_exit = 2'b00;
    logic       ext_vbus_ind = 1'b0;
    logic       vbus_cmp_valid = 1'b0;
    logic       ser6_en, ser3_en, clk_keep_en, autoresume_en, vbus_compl, vbus_state;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    phy_ifc_ctrl_reg u_phy_ifc_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_we(acc_we), .acc_rdata(acc_rdata), .ser_exit(ser_exit),
        .ext_vbus_ind(ext_vbus_ind), .vbus_cmp_valid(vbus_cmp_valid),
        .ser6_en(ser6_en), .ser3_en(ser3_en), .clk_keep_en(clk_keep_en),
        .autoresume_en(autoresume_en), .vbus_compl(vbus_compl), .vbus_state(vbus_state)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One write, strobe for exactly one cycle
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_addr = a; acc_wdata = d; acc_we = 1'b1;
        @(negedge clk);
        acc_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        acc_addr = a;
        #1;
        check(req, acc_rdata, exp);
    endtask

    task automatic t_reset;
        rd_check("R1", 8'h07, 8'h00);
        check("R1", {4'h0, ser6_en, ser3_en, clk_keep_en, autoresume_en}, 8'h00);
    endtask

    task automatic t_load;
        wr(8'h07, 8'hFF);
        rd_check("R2/R6", 8'h07, 8'h7B);
        wr(8'h07, 8'h12);
        rd_check("R2", 8'h07, 8'h12);
    endtask

    task automatic t_set_clear;
        wr(8'h08, 8'h21);
        rd_check("R3", 8'h08, 8'h33);
        wr(8'h09, 8'h11);
        rd_check("R4", 8'h09, 8'h22);
    endtask

    task automatic t_alias;
        rd_check("R5", 8'h07, 8'h22);
        rd_check("R5", 8'h08, 8'h22);
        rd_check("R5", 8'h09, 8'h22);
        rd_check("R5", 8'h0A, 8'h00);
        wr(8'h0A, 8'hFF);
        rd_check("R5", 8'h07, 8'h22);
    endtask

    task automatic t_reserved;
        wr(8'h08, 8'h84);
        rd_check("R6", 8'h07, 8'h22);
        wr(8'h09, 8'h84);
        rd_check("R6", 8'h07, 8'h22);
    endtask

    task automatic t_outputs;
        wr(8'h07, 8'h1B);
        check("R8", {4'h0, ser6_en, ser3_en, clk_keep_en, autoresume_en}, 8'h0F);
        wr(8'h07, 8'h08);
        check("R8", {4'h0, ser6_en, ser3_en, clk_keep_en, autoresume_en}, 8'h02);
    endtask

    task automatic t_hw_clear;
        wr(8'h07, 8'h03);
        @(negedge clk); ser_exit = 2'b01;
        @(negedge clk); ser_exit = 2'b00;
        check("R7", {6'h0, ser3_en, ser6_en}, 8'h02);
        @(negedge clk); ser_exit = 2'b10;
        @(negedge clk); ser_exit = 2'b00;
        check("R7", {6'h0, ser3_en, ser6_en}, 8'h00);
        // Set and exit in the same cycle: clear wins for bit 0, bit 1 set
        @(negedge clk);
        acc_addr = 8'h08; acc_wdata = 8'h03; acc_we = 1'b1; ser_exit = 2'b01;
        @(negedge clk);
        acc_we = 1'b0; ser_exit = 2'b00;
        rd_check("R7", 8'h07, 8'h02);
    endtask

    task automatic t_timing;
        @(negedge clk);
        acc_addr = 8'h07; acc_wdata = 8'h10; acc_we = 1'b1;
        #1 check("R11", acc_rdata, 8'h02);
        @(negedge clk);
        acc_we = 1'b0;
        #1 check("R11", acc_rdata, 8'h10);
    endtask

    task automatic t_vbus;
        for (int m = 0; m < 4; m++) begin
            wr(8'h07, 8'(m << 5));
            for (int k = 0; k < 4; k++) begin
                logic c, s;
                ext_vbus_ind = k[0]; vbus_cmp_valid = k[1];
                #1;
                c = k[0] ^ m[0];
                s = m[1] ? c : (c & k[1]);
                check("R9", {7'h0, vbus_compl}, {7'h0, c});
                check("R10", {7'h0, vbus_state}, {7'h0, s});
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_set_clear();
        t_alias();
        t_reserved();
        t_outputs();
        t_hw_clear();
        t_timing();
        t_vbus();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule